// File: doc/BRIEF.md
# Selectable Cascaded Halfband Interpolator

This block raises the sample rate of a two's-complement I/Q stream by 1, 2, 4 or 8. Three identical 2x halfband stages are chained. A two-bit rate input sets how many of them are active, counted from the input side, and the stages that are not active are bypassed. The block runs on the fast output clock. A new input pair arrives on a single-cycle enable, once every 2^N clocks when N stages are active. In steady state the last active stage delivers one I/Q pair on every clock.

Each stage uses polyphase form, so the zero-stuffed samples never reach a multiplier. In one phase a stage forms a symmetric six-tap sum of its delay line. In the other phase it passes the centre sample through. The filter is linear phase. A highpass selection applies (-1)^n to the impulse response of the last active stage only, so that stage passes the upper image instead of the lower one. Each sum is held in a wide accumulator, then rounded and saturated back to the sample width. When the rate or the highpass selection changes, every delay line and output register is cleared. Stale samples therefore never reach the output.

Top module: `hb_interp_chain`

## Requirements
- R1: `cfg_rate` selects the factor: 0 means 1x, 1 means 2x, 2 means 4x and 3 means 8x, so N = `cfg_rate` stages are active. Every accepted input pair produces exactly 2^N output pairs.
- R2: At rate 0 the input is registered straight through. `out_valid` is high in the cycle after `in_en`, carrying that cycle's input unchanged, and `cfg_highpass` has no effect.
- R3: For an input x[k], with x[k-j] = 0 before the first sample, a stage first emits sat(floor((3(x[k]+x[k-5]) - 25(x[k-1]+x[k-4]) + 150(x[k-2]+x[k-3]) + 128) / 256)).
- R4: A lowpass stage then emits x[k-2] unchanged as its second output for that input.
- R5: With `cfg_highpass` = 1 and N ≥ 1, only the last active stage emits sat(-x[k-2]) as its second output, so -2048 becomes +2047. The first output of that stage and all earlier stages behave as in R3 and R4.
- R6: Results outside [-2048, 2047] are clipped to the nearer limit at every stage.
- R7: The first `out_valid` comes 2N cycles after the cycle in which the first `in_en` is sampled, or 1 cycle at rate 0. After that, `out_valid` stays high on consecutive clocks until all the outputs have been delivered.
- R8: In the cycle after `cfg_rate` or `cfg_highpass` changes, `out_valid` is low and both outputs are 0. All filter history is discarded, and an `in_en` in the change cycle is dropped.
- R9: During reset and in the cycle after it, `out_valid`, `out_i` and `out_q` are all 0.
- R10: While `out_valid` is low and no configuration change has occurred, `out_i` and `out_q` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rate | input | 2 | Rate factor code (number of active stages) |
| cfg_highpass | input | 1 | Upper-image response for the last active stage |
| in_en | input | 1 | Input pair strobe, once every 2^N clocks |
| in_i | input | 12 | Input in-phase sample, two's complement |
| in_q | input | 12 | Input quadrature sample, two's complement |
| out_valid | output | 1 | Output pair valid |
| out_i | output | 12 | Output in-phase sample |
| out_q | output | 12 | Output quadrature sample |

## Verification
The bench sweeps every rate with both responses, using four input shapes, and changes the configuration between runs without resetting. An impulse that follows busy data therefore exposes any history left behind by an incomplete flush. A six-periodic full-scale pattern drives the symmetric sum past both rails. A design that wrapped instead of clipping would show a sign flip there. A constant -2048 input into a highpass stage catches a missing clip on negation. The bench also checks the first-output cycle against the per-mode latency and confirms that there are no gaps in steady state, which catches a wrong phase timer or an off-by-one in the strobe chain.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    // half the number of non-zero outer taps of each halfband stage
    localparam int HB_NC    = 3;
    // coefficient scale: taps are integers over 2**HB_SHIFT
    localparam int HB_SHIFT = 8;

    // outer taps from the edge of the delay line inward; the centre tap is 2**HB_SHIFT
    function automatic int hb_coef(input int j);
        case (j)
            0:       return 3;
            1:       return -25;
            default: return 150;
        endcase
    endfunction

endpackage

// File: rtl/hbi_cfg_ctl.sv
module hbi_cfg_ctl #(
    parameter int NST = 3,
    parameter int RW  = 2,
    parameter int PW  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [RW-1:0]            cfg_rate,
    input  logic                     cfg_highpass,
    output logic                     flush,
    output logic [RW-1:0]            rate,
    output logic [NST-1:0]           stage_en,
    output logic [NST-1:0]           stage_hp,
    output logic [NST-1:0][PW-1:0]   half_per
);

    typedef struct packed {
        logic [RW-1:0] rate;
        logic          hp;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d      = cfg_q;
        flush      = (cfg_rate != cfg_q.rate) || (cfg_highpass != cfg_q.hp);
        cfg_d.rate = cfg_rate;
        cfg_d.hp   = cfg_highpass;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign rate = cfg_q.rate;

    for (genvar g = 0; g < NST; g++) begin : g_stage_cfg
        assign stage_en[g] = (int'(cfg_q.rate) > g);
        assign stage_hp[g] = cfg_q.hp && (int'(cfg_q.rate) == g + 1);
        assign half_per[g] = stage_en[g] ? (PW'(1) << (int'(cfg_q.rate) - 1 - g)) : '0;
    end

endmodule

// File: rtl/hbi_stage.sv
module hbi_stage
    import hbi_pkg::*;
#(
    parameter int DW = 12,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [PW-1:0] half_per,
    input  logic          hp_en,
    input  logic          vin,
    input  logic [DW-1:0] xi,
    input  logic [DW-1:0] xq,
    output logic          vout,
    output logic [DW-1:0] yi,
    output logic [DW-1:0] yq
);

    localparam int TAPS  = 2 * HB_NC;
    localparam int ACC_W = DW + 13;
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (DW - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] RND  = ACC_W'(64'sd1 <<< (HB_SHIFT - 1));

    typedef logic [TAPS-1:0][DW-1:0] line_t;

    typedef struct packed {
        line_t         dl_i;
        line_t         dl_q;
        logic          even_pend;
        logic [PW-1:0] tmr;
        logic          vout;
        logic [DW-1:0] y_i;
        logic [DW-1:0] y_q;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [DW-1:0] clip(input logic signed [ACC_W-1:0] a);
        if (a > MAXV)      return MAXV[DW-1:0];
        else if (a < MINV) return MINV[DW-1:0];
        else               return a[DW-1:0];
    endfunction

    // symmetric sum over the outer taps, rounded half up
    function automatic logic [DW-1:0] sym_phase(input line_t d);
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] a;
        logic signed [ACC_W-1:0] b;
        logic signed [ACC_W-1:0] c;
        acc = '0;
        for (int j = 0; j < HB_NC; j++) begin
            a   = ACC_W'($signed(d[j]));
            b   = ACC_W'($signed(d[TAPS-1-j]));
            c   = ACC_W'(hb_coef(j));
            acc = acc + c * (a + b);
        end
        acc = acc + RND;
        return clip(acc >>> HB_SHIFT);
    endfunction

    // centre tap phase; the upper-image response flips its sign
    function automatic logic [DW-1:0] ctr_phase(input line_t d, input logic neg);
        logic signed [ACC_W-1:0] m;
        m = ACC_W'($signed(d[HB_NC-1]));
        if (neg) return clip(-m);
        else     return d[HB_NC-1];
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.vout = 1'b0;
        if (st_q.even_pend) begin
            st_d.vout      = 1'b1;
            st_d.y_i       = sym_phase(st_q.dl_i);
            st_d.y_q       = sym_phase(st_q.dl_q);
            st_d.even_pend = 1'b0;
            st_d.tmr       = half_per;
        end else if (st_q.tmr != '0) begin
            st_d.tmr = st_q.tmr - PW'(1);
            if (st_q.tmr == PW'(1)) begin
                st_d.vout = 1'b1;
                st_d.y_i  = ctr_phase(st_q.dl_i, hp_en);
                st_d.y_q  = ctr_phase(st_q.dl_q, hp_en);
            end
        end
        if (vin) begin
            st_d.dl_i      = {st_q.dl_i[TAPS-2:0], xi};
            st_d.dl_q      = {st_q.dl_q[TAPS-2:0], xq};
            st_d.even_pend = 1'b1;
        end
        if (flush) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vout = st_q.vout;
    assign yi   = st_q.y_i;
    assign yq   = st_q.y_q;

endmodule

// File: rtl/hbi_out_sel.sv
module hbi_out_sel #(
    parameter int DW  = 12,
    parameter int NST = 3,
    parameter int RW  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic [RW-1:0]          rate,
    input  logic                   in_en,
    input  logic [DW-1:0]          in_i,
    input  logic [DW-1:0]          in_q,
    input  logic [NST-1:0]         st_v,
    input  logic [NST-1:0][DW-1:0] st_i,
    input  logic [NST-1:0][DW-1:0] st_q,
    output logic                   out_valid,
    output logic [DW-1:0]          out_i,
    output logic [DW-1:0]          out_q
);

    localparam int SW = (NST > 1) ? $clog2(NST) : 1;

    typedef struct packed {
        logic          v;
        logic [DW-1:0] y_i;
        logic [DW-1:0] y_q;
    } byp_t;

    byp_t byp_d, byp_q;
    logic [SW-1:0] sel;

    always_comb begin
        byp_d   = byp_q;
        byp_d.v = 1'b0;
        if ((rate == '0) && in_en) begin
            byp_d.v   = 1'b1;
            byp_d.y_i = in_i;
            byp_d.y_q = in_q;
        end
        if (flush) byp_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) byp_q <= '0;
        else        byp_q <= byp_d;
    end

    assign sel = SW'(rate - RW'(1));

    always_comb begin
        if (rate == '0) begin
            out_valid = byp_q.v;
            out_i     = byp_q.y_i;
            out_q     = byp_q.y_q;
        end else begin
            out_valid = st_v[sel];
            out_i     = st_i[sel];
            out_q     = st_q[sel];
        end
    end

endmodule

// File: rtl/hb_interp_chain.sv
module hb_interp_chain #(
    parameter  int DW  = 12,
    parameter  int NST = 3,
    localparam int RW  = $clog2(NST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] cfg_rate,
    input  logic          cfg_highpass,
    input  logic          in_en,
    input  logic [DW-1:0] in_i,
    input  logic [DW-1:0] in_q,
    output logic          out_valid,
    output logic [DW-1:0] out_i,
    output logic [DW-1:0] out_q
);

    localparam int PW = $clog2(1 << (NST - 1)) + 1;

    logic                   flush;
    logic [RW-1:0]          rate;
    logic [NST-1:0]         stage_en;
    logic [NST-1:0]         stage_hp;
    logic [NST-1:0][PW-1:0] half_per;
    logic [NST-1:0]         sv;
    logic [NST-1:0][DW-1:0] si;
    logic [NST-1:0][DW-1:0] sq;

    hbi_cfg_ctl #(.NST(NST), .RW(RW), .PW(PW)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_rate     (cfg_rate),
        .cfg_highpass (cfg_highpass),
        .flush        (flush),
        .rate         (rate),
        .stage_en     (stage_en),
        .stage_hp     (stage_hp),
        .half_per     (half_per)
    );

    for (genvar g = 0; g < NST; g++) begin : g_stage
        logic          vin;
        logic [DW-1:0] xi;
        logic [DW-1:0] xq;
        if (g == 0) begin : g_head
            assign vin = in_en & stage_en[g];
            assign xi  = in_i;
            assign xq  = in_q;
        end else begin : g_link
            assign vin = sv[g-1] & stage_en[g];
            assign xi  = si[g-1];
            assign xq  = sq[g-1];
        end
        hbi_stage #(.DW(DW), .PW(PW)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .half_per (half_per[g]),
            .hp_en    (stage_hp[g]),
            .vin      (vin),
            .xi       (xi),
            .xq       (xq),
            .vout     (sv[g]),
            .yi       (si[g]),
            .yq       (sq[g])
        );
    end

    hbi_out_sel #(.DW(DW), .NST(NST), .RW(RW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .rate      (rate),
        .in_en     (in_en),
        .in_i      (in_i),
        .in_q      (in_q),
        .st_v      (sv),
        .st_i      (si),
        .st_q      (sq),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

endmodule

// File: rtl/hb_interp_chain_chk.sv
module hb_interp_chain_chk #(
    parameter int DW = 12,
    parameter int RW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [RW-1:0] cfg_rate,
    input logic          cfg_highpass,
    input logic          in_en,
    input logic [DW-1:0] in_i,
    input logic [DW-1:0] in_q,
    input logic          out_valid,
    input logic [DW-1:0] out_i,
    input logic [DW-1:0] out_q
);

    logic [RW-1:0] seen_rate;
    logic          seen_hp;
    logic          chg;
    logic          chg_q;

    assign chg = (cfg_rate != seen_rate) || (cfg_highpass != seen_hp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_rate <= '0;
            seen_hp   <= 1'b0;
            chg_q     <= 1'b0;
        end else begin
            seen_rate <= cfg_rate;
            seen_hp   <= cfg_highpass;
            chg_q     <= chg;
        end
    end

    assert_reset_idle_R9: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_i == '0 && out_q == '0));

    assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> (!out_valid && out_i == '0 && out_q == '0));

    assert_bypass_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!chg && cfg_rate == '0 && in_en) |=>
            (out_valid && out_i == $past(in_i) && out_q == $past(in_q)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !chg_q) |-> ($stable(out_i) && $stable(out_q)));

endmodule

bind hb_interp_chain hb_interp_chain_chk #(.DW(DW), .RW(RW)) u_chk (.*);

// File: tb/hb_interp_chain_bench.sv
`timescale 1ns/1ps
module hb_interp_chain_bench;

    localparam int NIN = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_rate = 2'd0;
    logic        cfg_highpass = 1'b0;
    logic        in_en = 1'b0;
    logic [11:0] in_i = '0;
    logic [11:0] in_q = '0;
    logic        out_valid;
    logic [11:0] out_i;
    logic [11:0] out_q;

    hb_interp_chain u_hb_interp_chain (
        .clk(clk), .rst_n(rst_n), .cfg_rate(cfg_rate), .cfg_highpass(cfg_highpass),
        .in_en(in_en), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;
    int lv_i [0:3][0:127];
    int lv_q [0:3][0:127];
    int exp_n, idx, first_c, last_c, cur_m, cur_p, cur_h;
    bit run_active = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    function automatic int sat12(input int v);
        if (v > 2047) return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    function automatic int pat(input int p, input int k, input int ch);
        case (p)
            0: return (k == 0) ? ((ch == 0) ? 2047 : -2048) : 0;
            1: if (ch == 0) return ((k % 6) == 2 || (k % 6) == 3) ? -2048 : 2047;
               else         return ((k % 6) == 2 || (k % 6) == 3) ? 2047 : -2048;
            2: if (ch == 0) return ((k * 73 + 19) * 97) % 4096 - 2048;
               else         return ((k * 151 + 5) * 61) % 4096 - 2048;
            default: return (ch == 0) ? -2048 : k * 256 - 2048;
        endcase
    endfunction

    function automatic string tag_for(input int p, input int m, input int h, input int k);
        if (m == 0) return "R2";
        if (h != 0) return "R5";
        if (p == 1) return "R6";
        if (p == 0) return "R8";
        return (k % 2 == 0) ? "R3" : "R4";
    endfunction

    // arithmetic model of N cascaded stages
    task automatic build(input int m, input int h);
        for (int s = 0; s < m; s++) begin
            int len = NIN << s;
            for (int k = 0; k < len; k++) begin
                int xi6 [0:5];
                int xq6 [0:5];
                for (int j = 0; j < 6; j++) begin
                    xi6[j] = (k - j >= 0) ? lv_i[s][k-j] : 0;
                    xq6[j] = (k - j >= 0) ? lv_q[s][k-j] : 0;
                end
                lv_i[s+1][2*k] = sat12((3*(xi6[0]+xi6[5]) - 25*(xi6[1]+xi6[4]) + 150*(xi6[2]+xi6[3]) + 128) >>> 8);
                lv_q[s+1][2*k] = sat12((3*(xq6[0]+xq6[5]) - 25*(xq6[1]+xq6[4]) + 150*(xq6[2]+xq6[3]) + 128) >>> 8);
                lv_i[s+1][2*k+1] = (h != 0 && s == m - 1) ? sat12(-xi6[2]) : xi6[2];
                lv_q[s+1][2*k+1] = (h != 0 && s == m - 1) ? sat12(-xq6[2]) : xq6[2];
            end
        end
    endtask

    always @(negedge clk) begin
        if (run_active && out_valid) begin
            if (first_c < 0) first_c = cyc;
            last_c = cyc;
            if (idx < exp_n) begin
                chk(int'($signed(out_i)) == lv_i[cur_m][idx], tag_for(cur_p, cur_m, cur_h, idx),
                    int'($signed(out_i)), lv_i[cur_m][idx]);
                chk(int'($signed(out_q)) == lv_q[cur_m][idx], tag_for(cur_p, cur_m, cur_h, idx),
                    int'($signed(out_q)), lv_q[cur_m][idx]);
            end else begin
                chk(1'b0, "R1 extra output", idx, exp_n);
            end
            idx++;
        end
    end

    task automatic run(input int p, input int m, input int h);
        bit changed;
        int d0;
        int lat;
        changed = (int'(cfg_rate) != m) || (int'(cfg_highpass) != h);
        cfg_rate     = 2'(m);
        cfg_highpass = 1'(h);
        @(negedge clk);
        if (changed)
            chk(!out_valid && out_i == '0 && out_q == '0, "R8 flush clears outputs",
                int'(out_valid) + int'(out_i != '0) + int'(out_q != '0), 0);
        repeat (2) @(negedge clk);
        for (int k = 0; k < NIN; k++) begin
            lv_i[0][k] = pat(p, k, 0);
            lv_q[0][k] = pat(p, k, 1);
        end
        build(m, h);
        exp_n = NIN << m;
        idx = 0; first_c = -1; last_c = -1;
        cur_m = m; cur_p = p; cur_h = h;
        run_active = 1;
        d0 = cyc;
        for (int k = 0; k < NIN; k++) begin
            in_i  = 12'(lv_i[0][k]);
            in_q  = 12'(lv_q[0][k]);
            in_en = 1'b1;
            @(negedge clk);
            in_en = 1'b0;
            repeat ((1 << m) - 1) @(negedge clk);
        end
        repeat (40) @(negedge clk);
        run_active = 0;
        lat = (m == 0) ? 1 : 2 * m;
        chk(idx == exp_n, "R1 output count", idx, exp_n);
        chk(first_c - d0 == lat, "R7 first output latency", first_c - d0, lat);
        chk(last_c - first_c == exp_n - 1, "R7 gap-free output", last_c - first_c, exp_n - 1);
        chk(!out_valid && int'($signed(out_i)) == lv_i[m][exp_n-1] && int'($signed(out_q)) == lv_q[m][exp_n-1],
            "R10 idle hold", int'($signed(out_i)), lv_i[m][exp_n-1]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!out_valid && out_i == '0 && out_q == '0, "R9 reset state",
            int'(out_valid) + int'(out_i != '0), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && out_i == '0 && out_q == '0, "R9 after reset",
            int'(out_valid) + int'(out_i != '0), 0);
        for (int p = 0; p < 4; p++)
            for (int m = 0; m < 4; m++)
                for (int h = 0; h < 2; h++)
                    run(p, m, h);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule